// File: doc/BRIEF.md
# MDIO Management Register Slave for a Gigabit PCS

This block is the management-side slave of a 1000BASE-X physical coding sublayer. It watches the serial management data line, which is sampled on each rising edge of the management clock. It recognises read and write frames addressed to its own PHY address and answers reads by driving the line. Behind the frame decoder sits a small, fixed register map: control, status, a two-word identifier, the local advertisement, the partner's advertised ability, auto-negotiation expansion, and extended status. The map is built for a PHY that only supports full duplex.

The control fields that matter to the rest of the PCS are brought out as ports. Loopback and auto-negotiation enable are levels. Core reset and negotiation restart are one-cycle pulses. The advertisement word is also brought out, for the negotiation engine. Link status, negotiation complete, page received and the partner ability word come in from that engine, and they appear in the status, expansion and partner registers. The management clock doubles as the block clock, and the line is split into an input, an output and an output enable, which feed an external tristate buffer.

Top module: `mdio_mgmt_regs`

## Requirements
- R1: A frame is acted on only when all of the following hold. At least 32 consecutive ones come first, then the bits 0,1, then an opcode: 10 for read, 01 for write. The 5-bit PHY address that follows must equal `phy_addr`. Frames with a short preamble, an opcode of 00 or 11, or another PHY address change no register and never drive the line.
- R2: After the 5-bit register address of a matching read, the line stays released for one bit time. The slave then drives 0 for one bit time, then drives the 16 data bits most significant first, then releases the line. Each driven value changes just after a rising clock edge.
- R3: Control (address 0) resets to 0x0140. Bit 14 (loopback) and bit 12 (auto-negotiation enable) are writable and appear on `loopback_en` and `an_enable`. Their new value shows two cycles after the edge that samples the last data bit.
- R4: Control bits 15 (reset) and 9 (restart) always read 0. A write with either bit at 1 gives a pulse of exactly one cycle on `pcs_reset_pulse` or `an_restart_pulse`, two cycles after the edge that samples the last data bit. Writes to other addresses give no pulse.
- R5: Writes do not affect control bits 13, 11, 10, 7 and 5..0, which read 0, nor bits 8 and 6, which read 1.
- R6: Status (address 1) reads 0x0109, with bit 2 following `link_up` and bit 5 following `an_done`. Writes do not affect it.
- R7: Address 2 reads 0x2222, address 3 reads 0x3333, address 15 reads 0x8000, and every other address outside 0..6 reads 0. Writes do not affect any of them.
- R8: Advertisement (address 4) resets to 0x0020. Only bits 8, 7 and 5 are writable. Bits 15, 13, 12 and 6 and all other bits read 0. The register's value is driven on `adv_ability`.
- R9: Address 5 reads `lp_ability` and is 0 out of reset. Address 6 reads `page_rx` in bit 1 and 0 in all other bits. Writes do not affect either register.
- R10: `mdio_oe` is high only during the turnaround-zero and data bits of a matching read, for exactly 17 consecutive cycles. It never rises during a write or an ignored frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; every register samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| phy_addr | input | 5 | PHY address this slave answers to |
| mdio_i | input | 1 | Sampled value of the management data line |
| mdio_o | output | 1 | Value to drive onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line; low means released |
| link_up | input | 1 | Live link status shown in status bit 2 |
| an_done | input | 1 | Negotiation-complete flag shown in status bit 5 |
| page_rx | input | 1 | Page-received flag shown in expansion bit 1 |
| lp_ability | input | 16 | Partner's advertised ability word |
| loopback_en | output | 1 | Loopback enable from control bit 14 |
| an_enable | output | 1 | Auto-negotiation enable from control bit 12 |
| pcs_reset_pulse | output | 1 | One-cycle pulse on a write of 1 to control bit 15 |
| an_restart_pulse | output | 1 | One-cycle pulse on a write of 1 to control bit 9 |
| adv_ability | output | 16 | Local advertisement word |

## Verification
The bound checker covers the line-drive rules on every cycle. The first driven bit of any read is 0, a drive never lasts longer than 17 cycles, each control pulse lasts a single cycle, and neither a pulse nor a loopback change ever overlaps a read drive. What the checker cannot see is register content. The bench reads every address under two sets of live inputs, and writes all-ones, all-zeros and walking-one patterns so that each read-only and hardwired bit is exposed. It also sends frames with every foreign PHY address, with bad opcodes and with a short preamble, and confirms at the ports that none of them has any effect.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int MDIO_DW = 16;
  localparam int MDIO_AW = 5;

  typedef logic [MDIO_DW-1:0] mdio_word_t;
  typedef logic [MDIO_AW-1:0] mdio_addr_t;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_START,
    FS_HDR,
    FS_RD_TA,
    FS_RD_DATA,
    FS_WRITE,
    FS_SKIP
  } frame_st_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  localparam mdio_addr_t A_CTRL   = 5'd0;
  localparam mdio_addr_t A_STAT   = 5'd1;
  localparam mdio_addr_t A_ID_HI  = 5'd2;
  localparam mdio_addr_t A_ID_LO  = 5'd3;
  localparam mdio_addr_t A_ADV    = 5'd4;
  localparam mdio_addr_t A_LPA    = 5'd5;
  localparam mdio_addr_t A_EXPN   = 5'd6;
  localparam mdio_addr_t A_EXTST  = 5'd15;

  localparam mdio_word_t CTRL_HARDWIRED = 16'h0140;
  localparam mdio_word_t CTRL_RW_MASK   = 16'h5000;
  localparam int         CTRL_RST_BIT   = 15;
  localparam int         CTRL_LB_BIT    = 14;
  localparam int         CTRL_ANE_BIT   = 12;
  localparam int         CTRL_RSTRT_BIT = 9;

  localparam mdio_word_t STAT_BASE      = 16'h0109;
  localparam int         STAT_LINK_BIT  = 2;
  localparam int         STAT_ANC_BIT   = 5;

  localparam mdio_word_t ADV_RESET      = 16'h0020;
  localparam mdio_word_t ADV_RW_MASK    = 16'h01A0;

  localparam int         EXPN_PAGE_BIT  = 1;
  localparam mdio_word_t EXT_STATUS     = 16'h8000;

endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mdio_i,
  input  mdio_addr_t phy_addr,
  input  mdio_word_t rd_data,
  output mdio_addr_t reg_addr,
  output logic       wr_en,
  output mdio_word_t wr_data,
  output logic       mdio_o,
  output logic       mdio_oe
);

  localparam int HDR_BITS  = 2 + 2 * MDIO_AW;
  localparam int TAIL_BITS = 2 + MDIO_DW;
  localparam int CNT_MAX   = (TAIL_BITS > HDR_BITS) ? TAIL_BITS : HDR_BITS;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int PRE_W     = $clog2(PREAMBLE_LEN + 1);

  frame_st_e            st;
  logic [PRE_W-1:0]     ones_cnt;
  logic [CNT_W-1:0]     bit_cnt;
  logic [HDR_BITS-1:0]  hdr_sh;
  mdio_word_t           shreg;
  mdio_addr_t           reg_addr_q;
  logic                 wr_en_q;
  mdio_word_t           wr_data_q;
  logic                 o_q;
  logic                 oe_q;

  logic [HDR_BITS-1:0]  hdr_next;
  logic [1:0]           hdr_op;
  mdio_addr_t           hdr_phy;
  mdio_addr_t           hdr_reg;
  logic                 phy_hit;

  always_comb begin
    hdr_next = {hdr_sh[HDR_BITS-2:0], mdio_i};
    hdr_op   = hdr_next[HDR_BITS-1 -: 2];
    hdr_phy  = hdr_next[2*MDIO_AW-1 -: MDIO_AW];
    hdr_reg  = hdr_next[MDIO_AW-1:0];
    phy_hit  = (hdr_phy == phy_addr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= FS_IDLE;
      ones_cnt   <= '0;
      bit_cnt    <= '0;
      hdr_sh     <= '0;
      shreg      <= '0;
      reg_addr_q <= '0;
      wr_en_q    <= 1'b0;
      wr_data_q  <= '0;
      o_q        <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      case (st)
        FS_IDLE: begin
          if (mdio_i) begin
            if (ones_cnt != PRE_W'(PREAMBLE_LEN)) ones_cnt <= ones_cnt + 1'b1;
          end else begin
            if (ones_cnt == PRE_W'(PREAMBLE_LEN)) st <= FS_START;
            ones_cnt <= '0;
          end
        end
        FS_START: begin
          bit_cnt <= '0;
          st      <= mdio_i ? FS_HDR : FS_IDLE;
        end
        FS_HDR: begin
          hdr_sh  <= hdr_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(HDR_BITS - 1)) begin
            bit_cnt    <= '0;
            reg_addr_q <= hdr_reg;
            if (phy_hit && hdr_op == OP_READ)       st <= FS_RD_TA;
            else if (phy_hit && hdr_op == OP_WRITE) st <= FS_WRITE;
            else                                    st <= FS_SKIP;
          end
        end
        FS_RD_TA: begin
          oe_q    <= 1'b1;
          o_q     <= 1'b0;
          shreg   <= rd_data;
          bit_cnt <= '0;
          st      <= FS_RD_DATA;
        end
        FS_RD_DATA: begin
          if (bit_cnt == CNT_W'(MDIO_DW)) begin
            oe_q <= 1'b0;
            o_q  <= 1'b0;
            st   <= FS_IDLE;
          end else begin
            o_q     <= shreg[MDIO_DW-1];
            shreg   <= {shreg[MDIO_DW-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        FS_WRITE: begin
          shreg   <= {shreg[MDIO_DW-2:0], mdio_i};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(TAIL_BITS - 1)) begin
            wr_en_q   <= 1'b1;
            wr_data_q <= {shreg[MDIO_DW-2:0], mdio_i};
            st        <= FS_IDLE;
          end
        end
        FS_SKIP: begin
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(TAIL_BITS - 1)) st <= FS_IDLE;
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  assign reg_addr = reg_addr_q;
  assign wr_en    = wr_en_q;
  assign wr_data  = wr_data_q;
  assign mdio_o   = o_q;
  assign mdio_oe  = oe_q;

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_pkg::*;
#(
  parameter mdio_word_t ID_HI = 16'h2222,
  parameter mdio_word_t ID_LO = 16'h3333
) (
  input  logic       clk,
  input  logic       rst,
  input  mdio_addr_t addr,
  input  logic       wr_en,
  input  mdio_word_t wr_data,
  output mdio_word_t rd_data,
  input  logic       link_up,
  input  logic       an_done,
  input  logic       page_rx,
  input  mdio_word_t lp_ability,
  output logic       loopback_en,
  output logic       an_enable,
  output logic       pcs_reset_pulse,
  output logic       an_restart_pulse,
  output mdio_word_t adv_ability
);

  mdio_word_t ctrl_q;
  mdio_word_t adv_q;
  mdio_word_t lpa_q;
  logic       rst_pulse_q;
  logic       rstrt_pulse_q;
  logic       ctrl_wr;
  logic       adv_wr;

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign adv_wr  = wr_en && (addr == A_ADV);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q        <= '0;
      adv_q         <= ADV_RESET;
      lpa_q         <= '0;
      rst_pulse_q   <= 1'b0;
      rstrt_pulse_q <= 1'b0;
    end else begin
      lpa_q         <= lp_ability;
      rst_pulse_q   <= ctrl_wr && wr_data[CTRL_RST_BIT];
      rstrt_pulse_q <= ctrl_wr && wr_data[CTRL_RSTRT_BIT];
      if (ctrl_wr) ctrl_q <= wr_data & CTRL_RW_MASK;
      if (adv_wr)  adv_q  <= wr_data & ADV_RW_MASK;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL:  rd_data = ctrl_q | CTRL_HARDWIRED;
      A_STAT: begin
        rd_data = STAT_BASE;
        rd_data[STAT_LINK_BIT] = link_up;
        rd_data[STAT_ANC_BIT]  = an_done;
      end
      A_ID_HI: rd_data = ID_HI;
      A_ID_LO: rd_data = ID_LO;
      A_ADV:   rd_data = adv_q;
      A_LPA:   rd_data = lpa_q;
      A_EXPN:  rd_data[EXPN_PAGE_BIT] = page_rx;
      A_EXTST: rd_data = EXT_STATUS;
      default: rd_data = '0;
    endcase
  end

  assign loopback_en      = ctrl_q[CTRL_LB_BIT];
  assign an_enable        = ctrl_q[CTRL_ANE_BIT];
  assign pcs_reset_pulse  = rst_pulse_q;
  assign an_restart_pulse = rstrt_pulse_q;
  assign adv_ability      = adv_q;

endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_pkg::*;
#(
  parameter int         PREAMBLE_LEN = 32,
  parameter mdio_word_t PHY_ID_HI    = 16'h2222,
  parameter mdio_word_t PHY_ID_LO    = 16'h3333
) (
  input  logic        mdc,
  input  logic        rst,
  input  logic [4:0]  phy_addr,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        link_up,
  input  logic        an_done,
  input  logic        page_rx,
  input  logic [15:0] lp_ability,
  output logic        loopback_en,
  output logic        an_enable,
  output logic        pcs_reset_pulse,
  output logic        an_restart_pulse,
  output logic [15:0] adv_ability
);

  mdio_addr_t reg_addr;
  logic       wr_en;
  mdio_word_t wr_data;
  mdio_word_t rd_data;

  mdio_frame_engine #(
    .PREAMBLE_LEN(PREAMBLE_LEN)
  ) u_frame (
    .clk     (mdc),
    .rst     (rst),
    .mdio_i  (mdio_i),
    .phy_addr(phy_addr),
    .rd_data (rd_data),
    .reg_addr(reg_addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

  mdio_reg_bank #(
    .ID_HI(PHY_ID_HI),
    .ID_LO(PHY_ID_LO)
  ) u_regs (
    .clk             (mdc),
    .rst             (rst),
    .addr            (reg_addr),
    .wr_en           (wr_en),
    .wr_data         (wr_data),
    .rd_data         (rd_data),
    .link_up         (link_up),
    .an_done         (an_done),
    .page_rx         (page_rx),
    .lp_ability      (lp_ability),
    .loopback_en     (loopback_en),
    .an_enable       (an_enable),
    .pcs_reset_pulse (pcs_reset_pulse),
    .an_restart_pulse(an_restart_pulse),
    .adv_ability     (adv_ability)
  );

endmodule

// File: rtl/mdio_mgmt_regs_chk.sv
module mdio_mgmt_regs_chk (
  input logic mdc,
  input logic rst,
  input logic mdio_o,
  input logic mdio_oe,
  input logic loopback_en,
  input logic pcs_reset_pulse,
  input logic an_restart_pulse
);

  logic [4:0] oe_run;

  always_ff @(posedge mdc) begin
    if (rst)          oe_run <= '0;
    else if (mdio_oe) oe_run <= oe_run + 5'd1;
    else              oe_run <= '0;
  end

  assert_ta_drives_zero_R2: assert property (@(posedge mdc) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o);

  assert_drive_window_R10: assert property (@(posedge mdc) disable iff (rst)
    oe_run <= 5'd17);

  assert_reset_pulse_single_R4: assert property (@(posedge mdc) disable iff (rst)
    pcs_reset_pulse |=> !pcs_reset_pulse);

  assert_restart_pulse_single_R4: assert property (@(posedge mdc) disable iff (rst)
    an_restart_pulse |=> !an_restart_pulse);

  assert_pulse_not_in_read_R10: assert property (@(posedge mdc) disable iff (rst)
    (pcs_reset_pulse || an_restart_pulse) |-> !mdio_oe);

  assert_loopback_change_no_drive_R3: assert property (@(posedge mdc) disable iff (rst)
    !$stable(loopback_en) |-> !mdio_oe);

endmodule

bind mdio_mgmt_regs mdio_mgmt_regs_chk u_chk (
  .mdc             (mdc),
  .rst             (rst),
  .mdio_o          (mdio_o),
  .mdio_oe         (mdio_oe),
  .loopback_en     (loopback_en),
  .pcs_reset_pulse (pcs_reset_pulse),
  .an_restart_pulse(an_restart_pulse)
);

// File: tb/sim_mdio_mgmt_regs.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_regs;

  localparam logic [4:0] MY_PHY = 5'h0B;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  phy_addr = MY_PHY;
  logic        mdio_i;
  logic        mdio_o, mdio_oe;
  logic        link_up, an_done, page_rx;
  logic [15:0] lp_ability;
  logic        loopback_en, an_enable, pcs_reset_pulse, an_restart_pulse;
  logic [15:0] adv_ability;

  int total = 0;
  int bad = 0;
  int stray = 0;
  bit finished = 0;
  logic [2:0] rp_seen, rs_seen;
  logic sh_lb, sh_ane;
  logic [15:0] sh_adv;

  always #2 clk = ~clk;

  mdio_mgmt_regs u0 (
    .mdc(clk), .rst(rst), .phy_addr(phy_addr), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .link_up(link_up), .an_done(an_done),
    .page_rx(page_rx), .lp_ability(lp_ability), .loopback_en(loopback_en),
    .an_enable(an_enable), .pcs_reset_pulse(pcs_reset_pulse),
    .an_restart_pulse(an_restart_pulse), .adv_ability(adv_ability)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input int a);
    case (a)
      0:  exp_rd = {1'b0, sh_lb, 1'b0, sh_ane, 3'b000, 1'b1, 1'b0, 1'b1, 6'b0};
      1:  exp_rd = 16'h0109 | (16'(link_up) << 2) | (16'(an_done) << 5);
      2:  exp_rd = 16'h2222;
      3:  exp_rd = 16'h3333;
      4:  exp_rd = sh_adv;
      5:  exp_rd = lp_ability;
      6:  exp_rd = 16'(page_rx) << 1;
      15: exp_rd = 16'h8000;
      default: exp_rd = 16'h0000;
    endcase
  endfunction

  function automatic string reg_tag(input int a);
    case (a)
      0: reg_tag = "R3";
      1: reg_tag = "R6";
      4: reg_tag = "R8";
      5, 6: reg_tag = "R9";
      default: reg_tag = "R7";
    endcase
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    if (mdio_oe) stray++;
    mdio_i = b;
  endtask

  task automatic send_header(input int pre_len, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
    for (int i = 0; i < pre_len; i++) send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(phy[i]);
    for (int i = 4; i >= 0; i--) send_bit(ra[i]);
  endtask

  // whole frame sent by the master, then three cycles of pulse capture
  task automatic do_write(input int pre_len, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    stray = 0;
    send_header(pre_len, op, phy, ra);
    send_bit(1'b1); send_bit(1'b0);
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (mdio_oe) stray++;
      rp_seen[i] = pcs_reset_pulse;
      rs_seen[i] = an_restart_pulse;
    end
  endtask

  task automatic do_read(input logic [4:0] ra, output logic [15:0] val, output bit ta_ok);
    stray = 0;
    send_header(32, 2'b10, MY_PHY, ra);
    @(negedge clk);
    ta_ok = (mdio_oe == 1'b0);
    mdio_i = 1'b1;
    @(negedge clk);
    ta_ok &= (mdio_oe == 1'b1) && (mdio_o == 1'b0);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      ta_ok &= mdio_oe;
      val[i] = mdio_o;
    end
    @(negedge clk);
    ta_ok &= !mdio_oe;
  endtask

  task automatic read_check(input int a);
    logic [15:0] v;
    bit ok;
    do_read(5'(a), v, ok);
    check(v == exp_rd(a), reg_tag(a), 32'(v), 32'(exp_rd(a)));
    check(ok && stray == 0, "R2", 32'(ok), 32'd1);
  endtask

  task automatic read_all();
    for (int a = 0; a < 32; a++) read_check(a);
  endtask

  task automatic write_mine(input int a, input logic [15:0] d);
    do_write(32, 2'b01, MY_PHY, 5'(a), d);
    if (a == 0) begin
      sh_lb  = d[14];
      sh_ane = d[12];
    end
    if (a == 4) sh_adv = d & 16'h01A0;
    check(rp_seen == ((a == 0 && d[15]) ? 3'b010 : 3'b000), "R4", 32'(rp_seen), 32'((a == 0 && d[15]) ? 3'b010 : 3'b000));
    check(rs_seen == ((a == 0 && d[9]) ? 3'b010 : 3'b000), "R4", 32'(rs_seen), 32'((a == 0 && d[9]) ? 3'b010 : 3'b000));
    check(loopback_en == sh_lb && an_enable == sh_ane, "R3", {30'b0, loopback_en, an_enable}, {30'b0, sh_lb, sh_ane});
    check(adv_ability == sh_adv, "R8", 32'(adv_ability), 32'(sh_adv));
    check(stray == 0, "R10", 32'(stray), 32'd0);
  endtask

  task automatic ignored_frame(input int pre_len, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    do_write(pre_len, op, phy, ra, d);
    check(stray == 0, "R1", 32'(stray), 32'd0);
    check(loopback_en == sh_lb && an_enable == sh_ane && adv_ability == sh_adv,
          "R1", {15'b0, loopback_en, adv_ability}, {15'b0, sh_lb, sh_adv});
    check(rp_seen == 3'b000 && rs_seen == 3'b000, "R1", {29'b0, rp_seen | rs_seen}, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mdio_i = 1'b1;
    link_up = 1'b1; an_done = 1'b0; page_rx = 1'b1; lp_ability = 16'hA5C3;
    sh_lb = 1'b0; sh_ane = 1'b0; sh_adv = 16'h0020;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state at the ports
    check(!loopback_en && !an_enable, "R3", {30'b0, loopback_en, an_enable}, 32'd0);
    check(adv_ability == 16'h0020, "R8", 32'(adv_ability), 32'h0020);
    check(!pcs_reset_pulse && !an_restart_pulse, "R4", {30'b0, pcs_reset_pulse, an_restart_pulse}, 32'd0);
    check(!mdio_oe, "R10", 32'(mdio_oe), 32'd0);

    // every address, first live-input pattern
    read_all();

    // second live-input pattern
    link_up = 1'b0; an_done = 1'b1; page_rx = 1'b0; lp_ability = 16'h5A3C;
    repeat (3) @(negedge clk);
    read_check(1); read_check(5); read_check(6);

    // all-ones then all-zeros written to every address, with read-back
    for (int a = 0; a < 32; a++) write_mine(a, 16'hFFFF);
    read_all();
    for (int a = 0; a < 32; a++) write_mine(a, 16'h0000);
    read_all();

    // walking one through control and advertisement
    for (int b = 0; b < 16; b++) begin
      logic [15:0] v;
      bit ok;
      write_mine(0, 16'(1) << b);
      do_read(5'd0, v, ok);
      check(v == exp_rd(0), "R5", 32'(v), 32'(exp_rd(0)));
      write_mine(4, 16'(1) << b);
      do_read(5'd4, v, ok);
      check(v == exp_rd(4), "R8", 32'(v), 32'(exp_rd(4)));
    end

    // ignored frames must leave loopback set and never drive
    write_mine(0, 16'h4000);
    for (int p = 0; p < 32; p++) begin
      if (p != int'(MY_PHY)) begin
        ignored_frame(32, 2'b01, 5'(p), 5'd0, 16'h0000);
        ignored_frame(32, 2'b10, 5'(p), 5'd2, 16'hFFFF);
      end
    end
    ignored_frame(32, 2'b00, MY_PHY, 5'd0, 16'h0000);
    ignored_frame(32, 2'b11, MY_PHY, 5'd0, 16'h0000);
    send_bit(1'b0);
    ignored_frame(31, 2'b01, MY_PHY, 5'd0, 16'h0000);
    write_mine(0, 16'h0000);
    check(!loopback_en, "R1", 32'(loopback_en), 32'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule